// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital search engine of a successive-approximation analog-to-digital converter. It sits between an external digital-to-analog converter and an external voltage comparator. A start request is accepted only while the block is idle. The block then clears its trial register and places a one in the most significant position. That code goes to the DAC, and the comparator answers with one bit that says whether the DAC level is above the analog input.

The block then tests one bit per clock, working down to bit zero. A bit is dropped when the comparator reports that the DAC level is above the input; otherwise it is kept. The next lower bit is raised in the same clock. After the last bit is decided, the final code is copied to the result output and a one-cycle done strobe is raised.

Every conversion takes the same number of clocks, whatever the input level. The code found is the largest one whose DAC level does not exceed the input, so the result is rounded down.

Top module: `sarConvTop`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the cycle after it is released, dacCode, result, done and busy are all zero.
- R2: When start is high at a clock edge while busy is low, busy is high and dacCode equals a one in bit WIDTH-1 with all other bits zero after that edge.
- R3: At each clock edge while busy, the bit under test (first WIDTH-1, then down to 0) is cleared if compHigh is 1 and kept if compHigh is 0. compHigh = 1 means the DAC level exceeds the input. In the same edge the next lower bit is set in dacCode. Bits already decided do not change.
- R4: busy stays high for exactly WIDTH consecutive cycles per conversion, independent of the compHigh values.
- R5: done is high for exactly one cycle, in the cycle right after busy falls, and busy is low in that cycle.
- R6: result changes only in a cycle where done is high. It then holds its value until the next conversion completes.
- R7: A start request while busy is high has no effect on the running conversion: its timing and its result are unchanged.
- R8: With an ideal comparator, result is the largest code k for which k steps do not exceed the input. Examples at WIDTH=8: an input of 11.2 steps gives 11; 37.5 steps gives 37; exactly 37 steps gives 37; 0 steps gives 0; above full scale gives 255.
- R9: A start request held high through the done cycle begins a new conversion on the next edge, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, taken only while idle |
| compHigh | input | 1 | Comparator: 1 when the DAC level is above the analog input |
| dacCode | output | WIDTH | Trial code sent to the external DAC |
| result | output | WIDTH | Last completed conversion code |
| done | output | 1 | One-cycle strobe when result is updated |
| busy | output | 1 | High while bits are being tested |

## Verification
The assertions assume that compHigh reflects the code driven in the previous cycle. They also assume the analog input does not move while busy is high. The bench makes this true by computing compHigh from dacCode against an input value held in tenths of a step. It changes that input only when no conversion is running. Start requests are changed only on the falling clock edge. Some are placed deliberately inside a running conversion, and some are held high across the done cycle.

// File: rtl/sarPkg.sv
package sarPkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sarState_e;

  typedef struct packed {
    logic loadFirst;
    logic trialStep;
    logic commit;
  } sarStrobe_t;
endpackage

// File: rtl/sarCtrlFsm.sv
module sarCtrlFsm
  import sarPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output sarStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  sarState_e state, stateNext;
  logic [CNT_W-1:0] stepCnt;
  logic lastStep;

  assign lastStep = (stepCnt == LAST_STEP);

  always_comb begin
    stateNext = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadFirst = 1'b1;
          stateNext = ST_CONV;
        end
      end
      ST_CONV: begin
        strobe.trialStep = 1'b1;
        if (lastStep) begin
          strobe.commit = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      stepCnt <= '0;
      done <= 1'b0;
    end else begin
      state <= stateNext;
      done <= strobe.commit;
      if (strobe.loadFirst) stepCnt <= '0;
      else if (strobe.trialStep) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state == ST_CONV);
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sarStrobe_t       strobe,
  input  logic             compHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trialReg;
  logic [WIDTH-1:0] probeMask;
  logic [WIDTH-1:0] decided;

  assign decided = compHigh ? (trialReg & ~probeMask) : trialReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      trialReg <= '0;
      probeMask <= '0;
      result <= '0;
    end else begin
      if (strobe.loadFirst) begin
        trialReg <= TOP_ONE;
        probeMask <= TOP_ONE;
      end else if (strobe.trialStep) begin
        trialReg <= decided | (probeMask >> 1);
        probeMask <= probeMask >> 1;
      end
      if (strobe.commit) result <= decided;
    end
  end

  assign dacCode = trialReg;
endmodule

// File: rtl/sarConvTop.sv
module sarConvTop
  import sarPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             compHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             busy
);
  sarStrobe_t strobe;

  sarCtrlFsm #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  sarDatapath #(.WIDTH(WIDTH)) data_i (
    .clk(clk), .rst(rst), .strobe(strobe), .compHigh(compHigh),
    .dacCode(dacCode), .result(result)
  );
endmodule

// File: rtl/sarConvChecker.sv
module sarConvChecker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             compHigh,
  input logic [WIDTH-1:0] dacCode,
  input logic [WIDTH-1:0] result,
  input logic             done,
  input logic             busy
);
  localparam int LEN_W = $clog2(WIDTH + 2) + 1;
  localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [LEN_W-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (rst) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  assert_first_trial_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && dacCode == TOP_ONE));

  assert_conv_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busyLen == LEN_W'(WIDTH)));

  assert_busy_ends_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);
endmodule

bind sarConvTop sarConvChecker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .start(start), .compHigh(compHigh),
  .dacCode(dacCode), .result(result), .done(done), .busy(busy)
);

// File: tb/sarConvTop_tb_top.sv
module sarConvTop_tb_top;
  localparam int WIDTH = 8;
  localparam int FULL = (1 << WIDTH) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic compHigh;
  logic [WIDTH-1:0] dacCode, result;
  logic done, busy;

  int vinTenths = 0;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  // ideal comparator: DAC level above input
  assign compHigh = (int'(dacCode) * 10 > vinTenths);

  sarConvTop #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .start(start), .compHigh(compHigh),
    .dacCode(dacCode), .result(result), .done(done), .busy(busy)
  );

  // behavioural reference, advanced on each rising edge from its own state
  bit mBusy = 0, mDone = 0;
  int mDac = 0, mResult = 0, mBit = 0, mSteps = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mBusy = 0; mDone = 0; mDac = 0; mResult = 0; mBit = 0; mSteps = 0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (start) begin
          mBusy = 1; mBit = WIDTH - 1; mDac = 1 << (WIDTH - 1); mSteps = 0;
        end
      end else begin
        mSteps++;
        if (mDac * 10 > vinTenths) mDac -= (1 << mBit);
        if (mBit == 0) begin
          mBusy = 0; mDone = 1; mResult = mDac;
        end else begin
          mBit--;
          mDac += (1 << mBit);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int floorCode(input int tenths);
    int k = tenths / 10;
    return (k > FULL) ? FULL : k;
  endfunction

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst) begin
      check(dacCode == 0 && result == 0 && !done && !busy, "R1 reset outputs",
            int'(dacCode) + int'(result) + int'(done) + int'(busy), 0);
    end else begin
      check(busy == mBusy, "R4 busy", busy, mBusy);
      check(done == mDone, "R5 done", done, mDone);
      check(int'(dacCode) == mDac, "R3 dacCode", dacCode, mDac);
      check(int'(result) == mResult, "R6 result", result, mResult);
      if (mDone) begin
        check(int'(result) == floorCode(vinTenths), "R8 rounded-down code",
              result, floorCode(vinTenths));
        check(mSteps == WIDTH, "R4 step count", mSteps, WIDTH);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic convert(input int tenths, input int lateStartAt);
    @(negedge clk);
    vinTenths = tenths;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: first trial is MSB only
    check(busy && dacCode == (1 << (WIDTH - 1)), "R2 first trial", dacCode, 1 << (WIDTH - 1));
    for (int i = 1; i <= WIDTH + 1; i++) begin
      if (i == lateStartAt) start = 1'b1;   // R7: request while busy
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dacCode == 0 && result == 0 && !done && !busy, "R1 after release",
          int'(dacCode) + int'(result), 0);
    convert(112, 0);        // R8: 11.2 steps -> 11
    convert(375, 0);        // R8: 37.5 steps -> 37
    convert(370, 0);        // R8: exact level is kept -> 37
    convert(0, 0);          // R8: zero
    convert(5000, 0);       // R8: above full scale -> 255
    convert(2551, 3);       // R7: start during conversion ignored
    convert(1234, WIDTH - 1); // R7: late request ignored
    convert(999, 1);
    // R9: start held high through several conversions
    @(negedge clk);
    vinTenths = 1777;
    start = 1'b1;
    repeat (3 * (WIDTH + 1) + 1) @(negedge clk);
    start = 1'b0;
    repeat (WIDTH + 3) @(negedge clk);
    // R6: result holds while idle with start low
    check(int'(result) == floorCode(1777), "R6 hold while idle", result, floorCode(1777));
    summary();
  end
endmodule